// File: doc/BRIEF.md
# Program Counter Sequencing Unit

This block works out where an 8-bit microcontroller goes next after each instruction. On every clock it takes the opcode, the one or two operand bytes that follow it, the current program counter and the few pieces of processor state that control-flow instructions consult. These are the accumulator, the data pointer, the carry flag, a resolved bit value, a loop counter value, a pair of compare operands and the address most recently popped from the stack. From these it produces the next program counter and any side requests the instruction makes. Those requests cover a return-address push, a stack pop, clearing the in-interrupt state, a carry write, a bit clear and a halt indication.

All outputs are registered and appear one clock after the inputs are presented. Instructions that do not change control flow simply advance by a length supplied by the instruction decoder. Stack storage, operand fetch and arithmetic are left to neighbouring blocks. All program counter arithmetic wraps modulo 2^16.

Top module: `pcseq_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge.
- R2: Opcodes with low five bits 00001 (page jump) or 10001 (page call) load `{pc[15:11], opcode[7:5], opnd1}`. A page call also raises `push_req` with `push_addr = pc+2`.
- R3: Opcode 0x02 (long jump) and 0x12 (long call) load `{opnd1, opnd2}`. The long call raises `push_req` with `push_addr = pc+3`.
- R4: Two-byte relative branches take their signed offset from `opnd1`. These are 0x80 (always), 0x40, 0x50, 0x60, 0x70 and 0xD8–0xDF. A taken branch loads `pc+2+offset` and an untaken one loads `pc+2`, modulo 2^16.
- R5: Three-byte relative branches take their signed offset from `opnd2`. These are 0x10, 0x20, 0x30, 0xB4–0xBF and 0xD5. A taken branch loads `pc+3+offset` and an untaken one loads `pc+3`, modulo 2^16.
- R6: The branch conditions are as follows. 0x40 branches on `carry_in`=1 and 0x50 on `carry_in`=0. 0x60 branches on `acc`==0 and 0x70 on `acc`!=0. 0x20 and 0x10 branch on `bit_val`=1, and 0x30 on `bit_val`=0. 0xD5 and 0xD8–0xDF branch on `cnt_val`!=0.
- R7: For compare-and-branch opcodes 0xB4–0xBF the block behaves as follows. `carry_we` is 1 and `carry_out` is 1 exactly when `cmp_lhs` < `cmp_rhs` (unsigned). The branch is taken exactly when the two differ.
- R8: `bit_clr` is 1 only for opcode 0x10 when its branch is taken.
- R9: Opcode 0x73 loads `dptr + acc` modulo 2^16.
- R10: Opcodes 0x22 and 0x32 load `stack_pc` and raise `pop_req`. Only 0x32 also raises `irq_clr`.
- R11: `halt` is 1 exactly when the opcode is 0x80 and the next program counter equals the current one, which happens when `opnd1` is 0xFE.
- R12: Any other opcode loads `pc + plain_len` and raises none of `push_req`, `pop_req`, `irq_clr`, `carry_we`, `bit_clr` or `halt`. For these opcodes `push_addr` and `carry_out` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 8 | Instruction opcode |
| opnd1 | input | 8 | First operand byte |
| opnd2 | input | 8 | Second operand byte |
| pc | input | 16 | Address of the current instruction |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| carry_in | input | 1 | Current carry flag |
| bit_val | input | 1 | Resolved value of the addressed bit |
| cmp_lhs | input | 8 | First compare operand |
| cmp_rhs | input | 8 | Second compare operand |
| cnt_val | input | 8 | Loop counter after its decrement |
| stack_pc | input | 16 | Return address popped from the stack |
| plain_len | input | 2 | Length of a non-control-flow instruction |
| next_pc | output | 16 | Next program counter |
| push_req | output | 1 | Request to push a return address |
| push_addr | output | 16 | Return address to push |
| pop_req | output | 1 | Request to pop a return address |
| irq_clr | output | 1 | Clear the in-interrupt state |
| carry_we | output | 1 | Write enable for the carry flag |
| carry_out | output | 1 | Carry value to write |
| bit_clr | output | 1 | Clear the tested bit |
| halt | output | 1 | Jump-to-self detected |

## Verification
The hardest cases to reach from the ports are arithmetic ones. They are a relative branch whose target wraps past 0xFFFF or below zero, a page jump sitting just below a 2 KiB boundary, and the exact self-loop offset that must flag a halt while neighbouring offsets must not. Uniformly random operands rarely land on these. The stimulus therefore places them deliberately: programme counters at 0xFFFE and 0x0001 with large positive and negative offsets, page opcodes at 0x07FF, and the 0x80 opcode with offsets 0xFE, 0xFD and 0xFF. A long random phase over all 256 opcodes follows, and every cycle is compared against a behavioural model.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int OP_W = 8;

    // Opcode values the sequencing logic depends on
    localparam logic [OP_W-1:0] OPC_LJMP  = 8'h02;
    localparam logic [OP_W-1:0] OPC_LCALL = 8'h12;
    localparam logic [OP_W-1:0] OPC_SJMP  = 8'h80;
    localparam logic [OP_W-1:0] OPC_JC    = 8'h40;
    localparam logic [OP_W-1:0] OPC_JNC   = 8'h50;
    localparam logic [OP_W-1:0] OPC_JZ    = 8'h60;
    localparam logic [OP_W-1:0] OPC_JNZ   = 8'h70;
    localparam logic [OP_W-1:0] OPC_RET   = 8'h22;
    localparam logic [OP_W-1:0] OPC_RETI  = 8'h32;
    localparam logic [OP_W-1:0] OPC_JIND  = 8'h73;
    localparam logic [OP_W-1:0] OPC_JBS   = 8'h20;
    localparam logic [OP_W-1:0] OPC_JBN   = 8'h30;
    localparam logic [OP_W-1:0] OPC_JBCLR = 8'h10;
    localparam logic [OP_W-1:0] OPC_LOOPD = 8'hD5;

    // How the next program counter is formed
    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_PAGE,
        FLOW_LONG,
        FLOW_REL2,
        FLOW_REL3,
        FLOW_IND,
        FLOW_RET
    } flow_e;

    // Which condition gates a relative branch
    typedef enum logic [3:0] {
        CND_ALWAYS,
        CND_CSET,
        CND_CCLR,
        CND_AZERO,
        CND_ANZ,
        CND_BSET,
        CND_BCLR,
        CND_CNTNZ,
        CND_DIFF
    } cond_e;

    typedef struct packed {
        flow_e flow;
        cond_e cond;
        logic  call;
        logic  is_ret;
        logic  irq_ret;
        logic  clr_bit;
        logic  cmp_carry;
    } dec_t;

    localparam dec_t DEC_IDLE = '{
        flow: FLOW_SEQ, cond: CND_ALWAYS, call: 1'b0, is_ret: 1'b0,
        irq_ret: 1'b0, clr_bit: 1'b0, cmp_carry: 1'b0
    };

endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
    import pcseq_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output dec_t            dec
);

    always_comb begin
        dec = DEC_IDLE;
        casez (opcode)
            8'b???0_0001: dec.flow = FLOW_PAGE;
            8'b???1_0001: begin
                dec.flow = FLOW_PAGE;
                dec.call = 1'b1;
            end
            OPC_LJMP: dec.flow = FLOW_LONG;
            OPC_LCALL: begin
                dec.flow = FLOW_LONG;
                dec.call = 1'b1;
            end
            OPC_SJMP: dec.flow = FLOW_REL2;
            OPC_JC: begin
                dec.flow = FLOW_REL2;
                dec.cond = CND_CSET;
            end
            OPC_JNC: begin
                dec.flow = FLOW_REL2;
                dec.cond = CND_CCLR;
            end
            OPC_JZ: begin
                dec.flow = FLOW_REL2;
                dec.cond = CND_AZERO;
            end
            OPC_JNZ: begin
                dec.flow = FLOW_REL2;
                dec.cond = CND_ANZ;
            end
            8'b1101_1???: begin
                dec.flow = FLOW_REL2;
                dec.cond = CND_CNTNZ;
            end
            OPC_LOOPD: begin
                dec.flow = FLOW_REL3;
                dec.cond = CND_CNTNZ;
            end
            OPC_JBS: begin
                dec.flow = FLOW_REL3;
                dec.cond = CND_BSET;
            end
            OPC_JBN: begin
                dec.flow = FLOW_REL3;
                dec.cond = CND_BCLR;
            end
            OPC_JBCLR: begin
                dec.flow    = FLOW_REL3;
                dec.cond    = CND_BSET;
                dec.clr_bit = 1'b1;
            end
            8'b1011_01??, 8'b1011_1???: begin
                dec.flow      = FLOW_REL3;
                dec.cond      = CND_DIFF;
                dec.cmp_carry = 1'b1;
            end
            OPC_JIND: dec.flow = FLOW_IND;
            OPC_RET: begin
                dec.flow   = FLOW_RET;
                dec.is_ret = 1'b1;
            end
            OPC_RETI: begin
                dec.flow    = FLOW_RET;
                dec.is_ret  = 1'b1;
                dec.irq_ret = 1'b1;
            end
            default: dec = DEC_IDLE;
        endcase
    end

endmodule

// File: rtl/pcseq_cond.sv
module pcseq_cond
    import pcseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  cond_e             cond,
    input  logic              carry_in,
    input  logic              bit_val,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic [DATA_W-1:0] cmp_lhs,
    input  logic [DATA_W-1:0] cmp_rhs,
    output logic              taken,
    output logic              cmp_lt
);

    logic acc_zero;
    logic cnt_zero;

    assign acc_zero = (acc == '0);
    assign cnt_zero = (cnt_val == '0);
    assign cmp_lt   = (cmp_lhs < cmp_rhs);

    always_comb begin
        unique case (cond)
            CND_ALWAYS: taken = 1'b1;
            CND_CSET:   taken = carry_in;
            CND_CCLR:   taken = ~carry_in;
            CND_AZERO:  taken = acc_zero;
            CND_ANZ:    taken = ~acc_zero;
            CND_BSET:   taken = bit_val;
            CND_BCLR:   taken = ~bit_val;
            CND_CNTNZ:  taken = ~cnt_zero;
            CND_DIFF:   taken = (cmp_lhs != cmp_rhs);
            default:    taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
    import pcseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  dec_t              dec,
    input  logic              taken,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] opnd1,
    input  logic [DATA_W-1:0] opnd2,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] acc,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [ADDR_W-1:0] stack_pc,
    input  logic [1:0]        plain_len,
    output logic [ADDR_W-1:0] next_pc,
    output logic [ADDR_W-1:0] ret_addr
);

    localparam int PAGE_W = DATA_W + 3;
    localparam int EXT_W  = ADDR_W - DATA_W;
    localparam int NLEN   = 2;

    logic [ADDR_W-1:0] step_pc [NLEN];
    logic [ADDR_W-1:0] rel_pc  [NLEN];
    logic [ADDR_W-1:0] page_pc;
    logic [ADDR_W-1:0] long_pc;
    logic [ADDR_W-1:0] ind_pc;
    logic [ADDR_W-1:0] seq_pc;

    // One adder pair per instruction length: entry k serves length k+2
    for (genvar k = 0; k < NLEN; k++) begin : g_rel
        localparam logic [ADDR_W-1:0] LEN = ADDR_W'(k + 2);
        logic [DATA_W-1:0] ofs;
        assign ofs        = (k == 0) ? opnd1 : opnd2;
        assign step_pc[k] = pc + LEN;
        assign rel_pc[k]  = step_pc[k] + {{EXT_W{ofs[DATA_W-1]}}, ofs};
    end

    assign page_pc = {pc[ADDR_W-1:PAGE_W], opcode[OP_W-1:OP_W-3], opnd1};
    assign long_pc = {opnd1, opnd2};
    assign ind_pc  = dptr + {{EXT_W{1'b0}}, acc};
    assign seq_pc  = pc + {{(ADDR_W-2){1'b0}}, plain_len};

    always_comb begin
        unique case (dec.flow)
            FLOW_PAGE: next_pc = page_pc;
            FLOW_LONG: next_pc = long_pc;
            FLOW_REL2: next_pc = taken ? rel_pc[0] : step_pc[0];
            FLOW_REL3: next_pc = taken ? rel_pc[1] : step_pc[1];
            FLOW_IND:  next_pc = ind_pc;
            FLOW_RET:  next_pc = stack_pc;
            default:   next_pc = seq_pc;
        endcase
    end

    // Page calls are two bytes long, long calls three
    assign ret_addr = (dec.flow == FLOW_PAGE) ? step_pc[0] : step_pc[1];

endmodule

// File: rtl/pcseq_unit.sv
module pcseq_unit
    import pcseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] opnd1,
    input  logic [DATA_W-1:0] opnd2,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] acc,
    input  logic [ADDR_W-1:0] dptr,
    input  logic              carry_in,
    input  logic              bit_val,
    input  logic [DATA_W-1:0] cmp_lhs,
    input  logic [DATA_W-1:0] cmp_rhs,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic [ADDR_W-1:0] stack_pc,
    input  logic [1:0]        plain_len,
    output logic [ADDR_W-1:0] next_pc,
    output logic              push_req,
    output logic [ADDR_W-1:0] push_addr,
    output logic              pop_req,
    output logic              irq_clr,
    output logic              carry_we,
    output logic              carry_out,
    output logic              bit_clr,
    output logic              halt
);

    dec_t              dec;
    logic              taken;
    logic              cmp_lt;
    logic [ADDR_W-1:0] nxt_c;
    logic [ADDR_W-1:0] ret_c;
    logic              halt_c;

    pcseq_decode u_decode (
        .opcode (opcode),
        .dec    (dec)
    );

    pcseq_cond #(.DATA_W(DATA_W)) u_cond (
        .cond     (dec.cond),
        .carry_in (carry_in),
        .bit_val  (bit_val),
        .acc      (acc),
        .cnt_val  (cnt_val),
        .cmp_lhs  (cmp_lhs),
        .cmp_rhs  (cmp_rhs),
        .taken    (taken),
        .cmp_lt   (cmp_lt)
    );

    pcseq_target #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_target (
        .dec       (dec),
        .taken     (taken),
        .opcode    (opcode),
        .opnd1     (opnd1),
        .opnd2     (opnd2),
        .pc        (pc),
        .acc       (acc),
        .dptr      (dptr),
        .stack_pc  (stack_pc),
        .plain_len (plain_len),
        .next_pc   (nxt_c),
        .ret_addr  (ret_c)
    );

    assign halt_c = (opcode == OPC_SJMP) && (nxt_c == pc);

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc   <= '0;
            push_req  <= 1'b0;
            push_addr <= '0;
            pop_req   <= 1'b0;
            irq_clr   <= 1'b0;
            carry_we  <= 1'b0;
            carry_out <= 1'b0;
            bit_clr   <= 1'b0;
            halt      <= 1'b0;
        end else begin
            next_pc   <= nxt_c;
            push_req  <= dec.call;
            push_addr <= dec.call ? ret_c : '0;
            pop_req   <= dec.is_ret;
            irq_clr   <= dec.irq_ret;
            carry_we  <= dec.cmp_carry;
            carry_out <= dec.cmp_carry & cmp_lt;
            bit_clr   <= dec.clr_bit & taken;
            halt      <= halt_c;
        end
    end

    // Reset clears every output register
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (next_pc == '0 && !push_req && push_addr == '0 && !pop_req &&
                 !irq_clr && !carry_we && !carry_out && !bit_clr && !halt));

    // Halt only when the registered next PC equals the PC presented
    assert_halt_self_R11: assert property (@(posedge clk) disable iff (rst)
        halt |-> (next_pc == $past(pc) && $past(opcode) == OPC_SJMP));

    // Returns and calls never happen together; interrupt clear only on a pop
    assert_push_pop_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(push_req && pop_req));
    assert_irq_needs_pop_R10: assert property (@(posedge clk) disable iff (rst)
        irq_clr |-> pop_req);

    // A bit clear follows only the bit-test-and-clear opcode
    assert_bit_clr_op_R8: assert property (@(posedge clk) disable iff (rst)
        bit_clr |-> ($past(opcode) == OPC_JBCLR && $past(bit_val)));

    // The carry written by a compare is the unsigned less-than of its operands
    assert_cmp_carry_R7: assert property (@(posedge clk) disable iff (rst)
        carry_we |-> (carry_out == ($past(cmp_lhs) < $past(cmp_rhs))));

    // A pushed return address lies two or three bytes past the instruction
    assert_push_len_R2: assert property (@(posedge clk) disable iff (rst)
        push_req |-> (push_addr == $past(pc) + 16'd2 || push_addr == $past(pc) + 16'd3));

endmodule

// File: tb/pcseq_unit_test.sv
module pcseq_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  opcode = '0, opnd1 = '0, opnd2 = '0, acc = '0;
    logic [7:0]  cmp_lhs = '0, cmp_rhs = '0, cnt_val = '0;
    logic [15:0] pc = '0, dptr = '0, stack_pc = '0;
    logic        carry_in = 1'b0, bit_val = 1'b0;
    logic [1:0]  plain_len = '0;

    logic [15:0] next_pc, push_addr;
    logic        push_req, pop_req, irq_clr, carry_we, carry_out, bit_clr, halt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pcseq_unit uut (
        .clk(clk), .rst(rst), .opcode(opcode), .opnd1(opnd1), .opnd2(opnd2),
        .pc(pc), .acc(acc), .dptr(dptr), .carry_in(carry_in), .bit_val(bit_val),
        .cmp_lhs(cmp_lhs), .cmp_rhs(cmp_rhs), .cnt_val(cnt_val),
        .stack_pc(stack_pc), .plain_len(plain_len),
        .next_pc(next_pc), .push_req(push_req), .push_addr(push_addr),
        .pop_req(pop_req), .irq_clr(irq_clr), .carry_we(carry_we),
        .carry_out(carry_out), .bit_clr(bit_clr), .halt(halt)
    );

    // Expected outputs, computed from the requirements with plain integers
    int    e_next, e_push, e_paddr, e_pop, e_irq, e_cwe, e_cout, e_bclr, e_halt;
    string e_tag;

    function automatic int sx(input int b);
        return (b >= 128) ? b - 256 : b;
    endfunction

    task automatic model();
        int op = opcode;
        int p  = pc;
        bit tk;
        e_push = 0; e_paddr = 0; e_pop = 0; e_irq = 0;
        e_cwe = 0; e_cout = 0; e_bclr = 0;
        if ((op % 32) == 1 || (op % 32) == 17) begin
            e_tag  = "R2";
            e_next = (p / 2048) * 2048 + (op / 32) * 256 + opnd1;
            if ((op % 32) == 17) begin e_push = 1; e_paddr = (p + 2) % 65536; end
        end else if (op == 'h02 || op == 'h12) begin
            e_tag  = "R3";
            e_next = opnd1 * 256 + opnd2;
            if (op == 'h12) begin e_push = 1; e_paddr = (p + 3) % 65536; end
        end else if (op == 'h80 || op == 'h40 || op == 'h50 || op == 'h60 ||
                     op == 'h70 || (op >= 'hD8 && op <= 'hDF)) begin
            case (op)
                'h80: begin tk = 1; e_tag = "R4"; end
                'h40: begin tk = carry_in; e_tag = "R4/R6"; end
                'h50: begin tk = !carry_in; e_tag = "R4/R6"; end
                'h60: begin tk = (acc == 0); e_tag = "R4/R6"; end
                'h70: begin tk = (acc != 0); e_tag = "R4/R6"; end
                default: begin tk = (cnt_val != 0); e_tag = "R4/R6"; end
            endcase
            e_next = tk ? (p + 2 + sx(opnd1) + 65536) % 65536 : (p + 2) % 65536;
        end else if (op == 'h10 || op == 'h20 || op == 'h30 || op == 'hD5 ||
                     (op >= 'hB4 && op <= 'hBF)) begin
            if (op >= 'hB4 && op <= 'hBF) begin
                tk = (cmp_lhs != cmp_rhs);
                e_cwe = 1; e_cout = (cmp_lhs < cmp_rhs);
                e_tag = "R5/R7";
            end else if (op == 'hD5) begin
                tk = (cnt_val != 0); e_tag = "R5/R6";
            end else if (op == 'h30) begin
                tk = !bit_val; e_tag = "R5/R6";
            end else begin
                tk = bit_val; e_tag = (op == 'h10) ? "R5/R8" : "R5/R6";
                if (op == 'h10) e_bclr = tk;
            end
            e_next = tk ? (p + 3 + sx(opnd2) + 65536) % 65536 : (p + 3) % 65536;
        end else if (op == 'h73) begin
            e_tag  = "R9";
            e_next = (dptr + acc) % 65536;
        end else if (op == 'h22 || op == 'h32) begin
            e_tag  = "R10";
            e_next = stack_pc; e_pop = 1; e_irq = (op == 'h32);
        end else begin
            e_tag  = "R12";
            e_next = (p + plain_len) % 65536;
        end
        e_halt = (op == 'h80) && (e_next == p);
        if (op == 'h80) e_tag = "R4/R11";
    endtask

    task automatic compare(input string tag);
        checks++;
        if (next_pc !== 16'(e_next) || push_req !== 1'(e_push) ||
            push_addr !== 16'(e_paddr) || pop_req !== 1'(e_pop) ||
            irq_clr !== 1'(e_irq) || carry_we !== 1'(e_cwe) ||
            carry_out !== 1'(e_cout) || bit_clr !== 1'(e_bclr) || halt !== 1'(e_halt)) begin
            fails++;
            $display("FAIL %s op=%02h: got next=%04h push=%0b/%04h pop=%0b irq=%0b cwe=%0b c=%0b bclr=%0b halt=%0b, expected next=%04h push=%0d/%04h pop=%0d irq=%0d cwe=%0d c=%0d bclr=%0d halt=%0d",
                     tag, opcode, next_pc, push_req, push_addr, pop_req, irq_clr, carry_we,
                     carry_out, bit_clr, halt, e_next, e_push, e_paddr, e_pop, e_irq,
                     e_cwe, e_cout, e_bclr, e_halt);
        end
    endtask

    // Drive at a falling edge, register at the rising edge, check at the next falling edge
    task automatic step();
        model();
        @(posedge clk);
        @(negedge clk);
        compare(e_tag);
    endtask

    task automatic put(input logic [7:0] op, input logic [7:0] a1, input logic [7:0] a2,
                       input logic [15:0] p);
        opcode = op; opnd1 = a1; opnd2 = a2; pc = p;
        step();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        // R1: reset holds every output at zero despite busy inputs
        opcode = 8'h12; opnd1 = 8'h55; opnd2 = 8'hAA; pc = 16'h1234; halt_setup();
        repeat (3) @(posedge clk);
        @(negedge clk);
        e_next = 0; e_push = 0; e_paddr = 0; e_pop = 0; e_irq = 0;
        e_cwe = 0; e_cout = 0; e_bclr = 0; e_halt = 0;
        compare("R1");
        rst = 1'b0;

        // R2: page jump and call, including the top of a 2 KiB page
        put(8'hE1, 8'h34, 8'h00, 16'h7F12);
        put(8'h71, 8'hFF, 8'h00, 16'h07FF);
        put(8'h11, 8'h00, 8'h00, 16'hFFFF);
        // R3: long jump and call, return address wrapping
        put(8'h02, 8'hBE, 8'hEF, 16'h0100);
        put(8'h12, 8'h12, 8'h34, 16'hFFFE);
        // R4: two-byte branches, wrapping both ways
        put(8'h80, 8'h05, 8'h00, 16'hFFFE);
        put(8'h80, 8'h80, 8'h00, 16'h0001);
        // R11: self jump halts, neighbours do not
        put(8'h80, 8'hFE, 8'h00, 16'h4000);
        put(8'h80, 8'hFD, 8'h00, 16'h4000);
        put(8'h80, 8'hFF, 8'h00, 16'h4000);
        // R6: each condition both ways
        carry_in = 1'b1; put(8'h40, 8'h10, 8'h00, 16'h0200); put(8'h50, 8'h10, 8'h00, 16'h0200);
        carry_in = 1'b0; put(8'h40, 8'h10, 8'h00, 16'h0200); put(8'h50, 8'h10, 8'h00, 16'h0200);
        acc = 8'h00; put(8'h60, 8'hF0, 8'h00, 16'h0300); put(8'h70, 8'hF0, 8'h00, 16'h0300);
        acc = 8'h01; put(8'h60, 8'hF0, 8'h00, 16'h0300); put(8'h70, 8'hF0, 8'h00, 16'h0300);
        cnt_val = 8'h00; put(8'hDB, 8'h20, 8'h00, 16'h0400); put(8'hD5, 8'h11, 8'h20, 16'h0400);
        cnt_val = 8'h01; put(8'hDB, 8'h20, 8'h00, 16'h0400); put(8'hD5, 8'h11, 8'h20, 16'h0400);
        // R5 / R8: bit tests, with and without clear
        bit_val = 1'b1; put(8'h20, 8'h07, 8'hFC, 16'h0500); put(8'h30, 8'h07, 8'hFC, 16'h0500);
        put(8'h10, 8'h07, 8'h7F, 16'hFFF0);
        bit_val = 1'b0; put(8'h20, 8'h07, 8'hFC, 16'h0500); put(8'h30, 8'h07, 8'hFC, 16'h0500);
        put(8'h10, 8'h07, 8'h7F, 16'hFFF0);
        // R7: compare below, equal and above
        cmp_lhs = 8'h10; cmp_rhs = 8'h20; put(8'hB4, 8'h20, 8'h08, 16'h0600);
        cmp_lhs = 8'h20; cmp_rhs = 8'h20; put(8'hB5, 8'h00, 8'h08, 16'h0600);
        cmp_lhs = 8'hFF; cmp_rhs = 8'h01; put(8'hBF, 8'h01, 8'h88, 16'h0600);
        // R9: indirect jump wrapping
        dptr = 16'hFFF0; acc = 8'h20; put(8'h73, 8'h00, 8'h00, 16'h0700);
        // R10: return and return from interrupt
        stack_pc = 16'hCAFE; put(8'h22, 8'h00, 8'h00, 16'h0800);
        stack_pc = 16'h0042; put(8'h32, 8'h00, 8'h00, 16'h0800);
        // R12: plain opcodes with every length
        for (int l = 0; l < 4; l++) begin
            plain_len = 2'(l);
            put(8'hE4, 8'h00, 8'h00, 16'hFFFE);
        end

        // Random phase over the whole opcode space
        for (int n = 0; n < 4000; n++) begin
            opcode   = 8'($urandom);  opnd1   = 8'($urandom); opnd2 = 8'($urandom);
            pc       = 16'($urandom); acc     = 8'($urandom % 4 == 0 ? 0 : $urandom);
            dptr     = 16'($urandom); carry_in = 1'($urandom); bit_val = 1'($urandom);
            cmp_lhs  = 8'($urandom % 8); cmp_rhs = 8'($urandom % 8);
            cnt_val  = 8'($urandom % 3); stack_pc = 16'($urandom);
            plain_len = 2'($urandom);
            if (n % 50 == 0) begin opcode = 8'h80; opnd1 = 8'hFE; end
            step();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic halt_setup();
        acc = 8'h33; dptr = 16'h1000; carry_in = 1'b1; bit_val = 1'b1;
        cmp_lhs = 8'h01; cmp_rhs = 8'h02; cnt_val = 8'h05; stack_pc = 16'h2222;
        plain_len = 2'd1;
    endtask

endmodule